// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm and Digital Trim

This block keeps the time of day and the calendar date in packed BCD registers: seconds, minutes, hours, day of month, month, two-digit year, a 3-bit weekday and a stored century byte. A prescaler counts an input tick enable and produces one calendar advance every `TICKS_PER_SEC` ticks. A small signed trim setting nudges that rate by whole prescaler counts once per correction window, so a slow or fast crystal can be corrected in 10 ppm steps.

A second bank with the same eight-field layout holds an alarm time. When the clock reaches the alarm in seconds, minutes, hours, day, month and year, a sticky flag is raised; weekday and century take no part in the comparison. A bus interface block reaches every register through a plain parallel write port and a combinational read port. The block accepts a write in any cycle and never applies back-pressure; there is no valid/ready handshake because every access completes in the cycle it is presented.

Top module: `rtc_bcd_clock`

## Requirements
- R1: Clock fields sit at byte addresses 0x30..0x37 and alarm fields at 0x00..0x07, both in the order seconds, minutes, hours, day, month, year, weekday, century; the trim register is at 0x10 and every other address reads 0x00. After reset the clock reads 00:00:00, day 0x01, month 0x01, year 0x00, weekday 0, century 0x20, and `alarm_o` is low.
- R2: With trim zero, seconds advance by exactly one for every `TICKS_PER_SEC` cycles with `tick_i` high, and hold in cycles without a tick.
- R3: Seconds and minutes count 0x00..0x59 in BCD, hours count 0x00..0x23 in bits 5:0; each wrap carries into the next field.
- R4: Hour bit 7 is a 24-hour flag that reads back as written and is never changed by counting; hour bit 6 reads zero.
- R5: The day of month wraps to 0x01 after 0x30 in April, June, September and November, and after 0x31 in the other long months, carrying into the month.
- R6: February ends at 0x29 in a leap year and at 0x28 otherwise; a year is leap when its two digits are divisible by 4, except year 0x00, which is leap only when the century value is divisible by 4 (0x20 leap, 0x19 not).
- R7: Month wraps from 0x12 to 0x01 and carries into the year; year wraps from 0x99 to 0x00 and increments the century.
- R8: Weekday increments by one at every midnight rollover and wraps from 6 to 0.
- R9: Trim bit 0 adds 2 units and bit 1 adds 1 unit, one unit being one prescaler count per `PPM_WINDOW` ticks (10 ppm at the default); bit 2 set removes those counts instead of adding them; trim bits 7:3 read zero.
- R10: `alarm_o` rises one cycle after seconds, minutes, hours (bits 5:0), day, month and year of both banks first become equal; weekday and century are ignored; it stays high until `alarm_clr_i`.
- R11: A write to a clock field in a cycle that would advance the clock stores the written value and drops that advance for the whole bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Prescaler count enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Write byte address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 8 | Read byte address |
| rd_data_o | output | 8 | Read data, combinational from `rd_addr_i` |
| alarm_clr_i | input | 1 | Clears the alarm flag |
| alarm_o | output | 1 | Sticky alarm-match flag |

## Verification
Every cycle the assertions watch that the seconds field holds without an advance, wraps 59 to 00 on one, keeps a same-cycle written value, that the 24-hour flag never moves without a write, that trim reads keep bits 7:3 clear, and that the alarm flag stays up until cleared. Month lengths, leap-year rules across centuries, the weekday wrap, the carry chain to the century and the exact seconds gained or lost under each trim code only show through the bench's scenarios, which compare every field with a calendar model run on integers.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int FIELD_N = 8;
  localparam int IDX_W   = $clog2(FIELD_N);

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic       hflag;
    logic [5:0] hour;
    logic [7:0] day;
    logic [7:0] mon;
    logic [7:0] year;
    logic [2:0] wday;
    logic [7:0] cent;
  } rtc_time_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) begin
      r[3:0] = 4'd0;
      r[7:4] = (v[7:4] >= 4'd9) ? 4'd0 : v[7:4] + 4'd1;
    end else begin
      r = {v[7:4], v[3:0] + 4'd1};
    end
    return r;
  endfunction

  function automatic int bcd_val(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic leap_year(input logic [7:0] yr, input logic [7:0] ce);
    int y;
    int c;
    y = bcd_val(yr);
    c = bcd_val(ce);
    if (y == 0) return (c % 4) == 0;
    return (y % 4) == 0;
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mo, input logic [7:0] yr,
                                            input logic [7:0] ce);
    case (mo)
      8'h02:                      return leap_year(yr, ce) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] get_field(input rtc_time_t t, input logic [IDX_W-1:0] i);
    case (i)
      3'd0:    return t.sec;
      3'd1:    return t.min;
      3'd2:    return {t.hflag, 1'b0, t.hour};
      3'd3:    return t.day;
      3'd4:    return t.mon;
      3'd5:    return t.year;
      3'd6:    return {5'd0, t.wday};
      default: return t.cent;
    endcase
  endfunction

  function automatic rtc_time_t put_field(input rtc_time_t t, input logic [IDX_W-1:0] i,
                                          input logic [7:0] d);
    rtc_time_t r;
    r = t;
    case (i)
      3'd0: r.sec = d;
      3'd1: r.min = d;
      3'd2: begin
        r.hflag = d[7];
        r.hour  = d[5:0];
      end
      3'd3: r.day  = d;
      3'd4: r.mon  = d;
      3'd5: r.year = d;
      3'd6: r.wday = d[2:0];
      default: r.cent = d;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int PPM_WINDOW    = 100000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [2:0] trim_i,
  output logic       sec_adv_o
);
  localparam int PW = $clog2(TICKS_PER_SEC) + 2;
  localparam int WW = $clog2(PPM_WINDOW + 1);

  logic [PW-1:0] pre_q;
  logic [WW-1:0] win_q;
  logic [1:0]    debt_q;
  logic [1:0]    units;
  logic          win_end;
  logic [PW-1:0] step;
  logic [PW-1:0] sum;

  assign units   = {trim_i[0], trim_i[1]};
  assign win_end = tick_i && (win_q == WW'(PPM_WINDOW - 1));

  always_comb begin
    if (debt_q != 2'd0)                step = '0;
    else if (win_end && units != 2'd0) step = trim_i[2] ? '0 : PW'(units) + PW'(1);
    else                               step = PW'(1);
  end

  assign sum       = pre_q + step;
  assign sec_adv_o = tick_i && (sum >= PW'(TICKS_PER_SEC));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      win_q  <= '0;
      debt_q <= '0;
    end else if (tick_i) begin
      win_q <= win_end ? '0 : win_q + WW'(1);
      pre_q <= sec_adv_o ? sum - PW'(TICKS_PER_SEC) : sum;
      if (debt_q != 2'd0)
        debt_q <= debt_q - 2'd1;
      else if (win_end && trim_i[2] && units != 2'd0)
        debt_q <= units - 2'd1;
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sec_adv_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [7:0]       wr_data_i,
  output rtc_time_t        time_o
);
  rtc_time_t cur_q;
  rtc_time_t nxt;
  logic [7:0] last_day;

  assign last_day = month_last(cur_q.mon, cur_q.year, cur_q.cent);

  always_comb begin
    nxt = cur_q;
    if (sec_adv_i) begin
      if (cur_q.sec != 8'h59) begin
        nxt.sec = bcd_inc(cur_q.sec);
      end else begin
        nxt.sec = 8'h00;
        if (cur_q.min != 8'h59) begin
          nxt.min = bcd_inc(cur_q.min);
        end else begin
          nxt.min = 8'h00;
          if ({2'b00, cur_q.hour} != 8'h23) begin
            nxt.hour = bcd_inc({2'b00, cur_q.hour})[5:0];
          end else begin
            nxt.hour = 6'h00;
            nxt.wday = (cur_q.wday >= 3'd6) ? 3'd0 : cur_q.wday + 3'd1;
            if (cur_q.day != last_day) begin
              nxt.day = bcd_inc(cur_q.day);
            end else begin
              nxt.day = 8'h01;
              if (cur_q.mon != 8'h12) begin
                nxt.mon = bcd_inc(cur_q.mon);
              end else begin
                nxt.mon = 8'h01;
                if (cur_q.year != 8'h99) begin
                  nxt.year = bcd_inc(cur_q.year);
                end else begin
                  nxt.year = 8'h00;
                  nxt.cent = bcd_inc(cur_q.cent);
                end
              end
            end
          end
        end
      end
    end
    if (wr_en_i) nxt = put_field(cur_q, wr_idx_i, wr_data_i);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cur_q       <= '0;
      cur_q.day   <= 8'h01;
      cur_q.mon   <= 8'h01;
      cur_q.cent  <= 8'h20;
    end else begin
      cur_q <= nxt;
    end
  end

  assign time_o = cur_q;
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [7:0]       wr_data_i,
  input  rtc_time_t        now_i,
  input  logic             clr_i,
  output rtc_time_t        bank_o,
  output logic             flag_o
);
  rtc_time_t bank_q;
  logic      match;
  logic      match_q;
  logic      flag_q;

  assign match = (bank_q.sec  == now_i.sec)  && (bank_q.min  == now_i.min) &&
                 (bank_q.hour == now_i.hour) && (bank_q.day  == now_i.day) &&
                 (bank_q.mon  == now_i.mon)  && (bank_q.year == now_i.year);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      bank_q  <= '0;
      match_q <= 1'b1;
      flag_q  <= 1'b0;
    end else begin
      if (wr_en_i) bank_q <= put_field(bank_q, wr_idx_i, wr_data_i);
      match_q <= match;
      if (match && !match_q) flag_q <= 1'b1;
      else if (clr_i)        flag_q <= 1'b0;
    end
  end

  assign bank_o = bank_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/rtc_bcd_clock.sv
module rtc_bcd_clock
  import rtc_pkg::*;
#(
  parameter int         TICKS_PER_SEC = 32768,
  parameter int         PPM_WINDOW    = 100000,
  parameter logic [7:0] CLK_BASE      = 8'h30,
  parameter logic [7:0] ALM_BASE      = 8'h00,
  parameter logic [7:0] TRIM_ADDR     = 8'h10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [7:0] rd_addr_i,
  output logic [7:0] rd_data_o,
  input  logic       alarm_clr_i,
  output logic       alarm_o
);
  localparam int BANK_HI = 8 - IDX_W;

  rtc_time_t  now_t;
  rtc_time_t  alm_t;
  logic [2:0] trim_q;
  logic       sec_adv;
  logic       wr_clk;
  logic       wr_alm;

  assign wr_clk = wr_en_i && (wr_addr_i[7:IDX_W] == CLK_BASE[7:IDX_W]);
  assign wr_alm = wr_en_i && (wr_addr_i[7:IDX_W] == ALM_BASE[7:IDX_W]);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                                 trim_q <= '0;
    else if (wr_en_i && wr_addr_i == TRIM_ADDR)  trim_q <= wr_data_i[2:0];
  end

  rtc_prescaler #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .PPM_WINDOW   (PPM_WINDOW)
  ) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .trim_i   (trim_q),
    .sec_adv_o(sec_adv)
  );

  rtc_calendar u_cal (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sec_adv_i(sec_adv),
    .wr_en_i  (wr_clk),
    .wr_idx_i (wr_addr_i[IDX_W-1:0]),
    .wr_data_i(wr_data_i),
    .time_o   (now_t)
  );

  rtc_alarm u_alm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_alm),
    .wr_idx_i (wr_addr_i[IDX_W-1:0]),
    .wr_data_i(wr_data_i),
    .now_i    (now_t),
    .clr_i    (alarm_clr_i),
    .bank_o   (alm_t),
    .flag_o   (alarm_o)
  );

  always_comb begin
    if (rd_addr_i[7:IDX_W] == CLK_BASE[7:BANK_HI-BANK_HI+IDX_W])
      rd_data_o = get_field(now_t, rd_addr_i[IDX_W-1:0]);
    else if (rd_addr_i[7:IDX_W] == ALM_BASE[7:IDX_W])
      rd_data_o = get_field(alm_t, rd_addr_i[IDX_W-1:0]);
    else if (rd_addr_i == TRIM_ADDR)
      rd_data_o = {5'd0, trim_q};
    else
      rd_data_o = 8'h00;
  end
endmodule

// File: rtl/rtc_bcd_clock_chk.sv
module rtc_bcd_clock_chk #(
  parameter logic [7:0] CLK_BASE  = 8'h30,
  parameter logic [7:0] TRIM_ADDR = 8'h10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sec_adv,
  input logic       wr_en,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [7:0] sec,
  input logic       hflag,
  input logic [7:0] rd_addr,
  input logic [7:0] rd_data,
  input logic       alarm,
  input logic       alarm_clr
);
  logic wr_clk;
  assign wr_clk = wr_en && (wr_addr[7:3] == CLK_BASE[7:3]);

  p_sec_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_adv && !wr_clk) |=> $stable(sec));

  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_adv && !wr_clk && sec == 8'h59) |=> (sec == 8'h00));

  p_hflag_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == (CLK_BASE + 8'd2)) |=> $stable(hflag));

  p_trim_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == TRIM_ADDR) |-> (rd_data[7:3] == 5'd0));

  p_alarm_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && !alarm_clr) |=> alarm);

  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_adv && wr_en && wr_addr == CLK_BASE) |=> (sec == $past(wr_data)));
endmodule

bind rtc_bcd_clock rtc_bcd_clock_chk #(
  .CLK_BASE (CLK_BASE),
  .TRIM_ADDR(TRIM_ADDR)
) u_chk (
  .clk      (clk_i),
  .rst_n    (rst_ni),
  .sec_adv  (sec_adv),
  .wr_en    (wr_en_i),
  .wr_addr  (wr_addr_i),
  .wr_data  (wr_data_i),
  .sec      (now_t.sec),
  .hflag    (now_t.hflag),
  .rd_addr  (rd_addr_i),
  .rd_data  (rd_data_o),
  .alarm    (alarm_o),
  .alarm_clr(alarm_clr_i)
);

// File: tb/tb_rtc_bcd_clock.sv
module tb_rtc_bcd_clock;
  localparam int TPS = 4;
  localparam int WIN = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       alarm_clr = 1'b0;
  logic       alarm;

  int checks = 0;
  int fails = 0;

  int m_sec, m_min, m_hour, m_day, m_mon, m_year, m_wday, m_cent, m_flag;

  rtc_bcd_clock #(.TICKS_PER_SEC(TPS), .PPM_WINDOW(WIN)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .alarm_clr_i(alarm_clr), .alarm_o(alarm)
  );

  always #10 clk = ~clk;

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic logic [7:0] b2(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int mdays(int mo, int yr, int ce);
    int full;
    full = ce * 100 + yr;
    if (mo == 2)
      return ((full % 4 == 0) && ((full % 100 != 0) || (full % 400 == 0))) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_step();
    m_sec++;
    if (m_sec == 60) begin m_sec = 0; m_min++; end
    if (m_min == 60) begin
      m_min = 0; m_hour++;
      if (m_hour == 24) begin
        m_hour = 0;
        m_wday = (m_wday + 1) % 7;
        m_day++;
        if (m_day > mdays(m_mon, m_year, m_cent)) begin
          m_day = 1; m_mon++;
          if (m_mon == 13) begin
            m_mon = 1; m_year++;
            if (m_year == 100) begin m_year = 0; m_cent++; end
          end
        end
      end
    end
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tick = 1'b0; wr_en = 1'b0; alarm_clr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic load_model();
    wr(8'h30, b2(m_sec));
    wr(8'h31, b2(m_min));
    wr(8'h32, {1'(m_flag), 1'b0, 6'(b2(m_hour))});
    wr(8'h33, b2(m_day));
    wr(8'h34, b2(m_mon));
    wr(8'h35, b2(m_year));
    wr(8'h36, 8'(m_wday));
    wr(8'h37, b2(m_cent));
  endtask

  task automatic check_model(string day_tag);
    logic [7:0] v;
    rd(8'h30, v); chk("R3 seconds", v, b2(m_sec));
    rd(8'h31, v); chk("R3 minutes", v, b2(m_min));
    rd(8'h32, v); chk("R3/R4 hours", v, {1'(m_flag), 1'b0, 6'(b2(m_hour))});
    rd(8'h33, v); chk(day_tag, v, b2(m_day));
    rd(8'h34, v); chk("R7 month", v, b2(m_mon));
    rd(8'h35, v); chk("R7 year", v, b2(m_year));
    rd(8'h36, v); chk("R8 weekday", v, 8'(m_wday));
    rd(8'h37, v); chk("R7 century", v, b2(m_cent));
  endtask

  task automatic run_case(int s, int mi, int h, int fl, int d, int mo, int y, int wd,
                          int c, int secs, string day_tag);
    m_sec = s; m_min = mi; m_hour = h; m_flag = fl; m_day = d; m_mon = mo;
    m_year = y; m_wday = wd; m_cent = c;
    load_model();
    ticks(secs * TPS);
    for (int i = 0; i < secs; i++) model_step();
    check_model(day_tag);
  endtask

  task automatic trim_case(logic [7:0] code, logic [7:0] exp_sec, string tag);
    logic [7:0] v;
    do_reset();
    wr(8'h10, code);
    ticks(44);
    rd(8'h30, v);
    chk(tag, v, exp_sec);
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240607));
    do_reset();

    // R1 reset values and map
    rd(8'h30, v); chk("R1 reset seconds", v, 8'h00);
    rd(8'h32, v); chk("R1 reset hours", v, 8'h00);
    rd(8'h33, v); chk("R1 reset day", v, 8'h01);
    rd(8'h34, v); chk("R1 reset month", v, 8'h01);
    rd(8'h37, v); chk("R1 reset century", v, 8'h20);
    chk("R1 reset alarm flag", {7'd0, alarm}, 8'h00);
    wr(8'h05, 8'h47);
    rd(8'h05, v); chk("R1 alarm year readback", v, 8'h47);
    rd(8'h35, v); chk("R1 clock year untouched", v, 8'h00);
    rd(8'h20, v); chk("R1 unmapped reads zero", v, 8'h00);
    wr(8'h05, 8'h00);

    // R2 one second per TPS ticks, none without ticks
    ticks(TPS - 1);
    rd(8'h30, v); chk("R2 before full count", v, 8'h00);
    repeat (5) @(negedge clk);
    ticks(1);
    rd(8'h30, v); chk("R2 one second", v, 8'h01);
    ticks(3 * TPS);
    rd(8'h30, v); chk("R2 four seconds", v, 8'h04);

    // R4 flag survives counting across midnight
    run_case(59, 59, 23, 1, 10, 3, 24, 2, 20, 1, "R5 day");

    // R5/R6/R7/R8 directed corners
    run_case(59, 59, 23, 0, 30, 4, 10, 6, 20, 1, "R5 April end");
    run_case(59, 59, 23, 0, 30, 1, 10, 3, 20, 1, "R5 January 30th");
    run_case(59, 59, 23, 0, 28, 2, 0, 1, 19, 1, "R6 Feb 1900");
    run_case(59, 59, 23, 0, 28, 2, 0, 1, 20, 1, "R6 Feb 2000");
    run_case(59, 59, 23, 0, 28, 2, 24, 1, 20, 1, "R6 Feb 2024");
    run_case(59, 59, 23, 0, 29, 2, 24, 1, 20, 1, "R6 Feb 29 end");
    run_case(59, 59, 23, 1, 31, 12, 99, 6, 20, 1, "R7 century rollover");

    // randomized near-boundary cases
    for (int n = 0; n < 40; n++) begin
      int mo, yr, ce;
      mo = $urandom_range(12, 1);
      case ($urandom_range(4, 0))
        0: yr = 0;
        1: yr = 99;
        2: yr = 4 * $urandom_range(24, 1);
        default: yr = $urandom_range(99, 0);
      endcase
      ce = $urandom_range(20, 19);
      run_case($urandom_range(59, 50), $urandom_range(59, 58), $urandom_range(23, 22),
               $urandom_range(1, 0), mdays(mo, yr, ce) - $urandom_range(1, 0), mo, yr,
               $urandom_range(6, 0), ce, $urandom_range(12, 1), "R5/R6 random day");
    end

    // R10 alarm: weekday and century differ, flag sticky until clear
    m_sec = 57; m_min = 30; m_hour = 8; m_flag = 0; m_day = 15; m_mon = 6;
    m_year = 33; m_wday = 2; m_cent = 20;
    load_model();
    wr(8'h00, 8'h59); wr(8'h01, 8'h30); wr(8'h02, 8'h08); wr(8'h03, 8'h15);
    wr(8'h04, 8'h06); wr(8'h05, 8'h33); wr(8'h06, 8'h05); wr(8'h07, 8'h19);
    ticks(TPS);
    @(negedge clk);
    chk("R10 no flag before match", {7'd0, alarm}, 8'h00);
    ticks(TPS);
    @(negedge clk);
    chk("R10 flag on match", {7'd0, alarm}, 8'h01);
    ticks(2 * TPS);
    chk("R10 flag sticky", {7'd0, alarm}, 8'h01);
    @(negedge clk); alarm_clr = 1'b1;
    @(negedge clk); alarm_clr = 1'b0;
    chk("R10 flag cleared", {7'd0, alarm}, 8'h00);

    // R11 write beats a same-cycle advance
    wr(8'h30, 8'h20);
    wr(8'h31, 8'h07);
    ticks(TPS - 1);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 8'h30; wr_data = 8'h10;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    rd(8'h30, v); chk("R11 written seconds kept", v, 8'h10);
    rd(8'h31, v); chk("R11 minutes untouched", v, 8'h07);

    // R9 trim: 44 ticks, window of 20, 4 ticks per second
    trim_case(8'h00, 8'h11, "R9 trim zero");
    trim_case(8'h01, 8'h12, "R9 trim +2 units");
    trim_case(8'h02, 8'h11, "R9 trim +1 unit");
    trim_case(8'h03, 8'h12, "R9 trim +3 units");
    trim_case(8'h05, 8'h10, "R9 trim -2 units");
    trim_case(8'h07, 8'h09, "R9 trim -3 units");
    wr(8'h10, 8'hFF);
    rd(8'h10, v); chk("R9 trim upper bits zero", v, 8'h07);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule